// File: doc/BRIEF.md
# Line Printer Command Controller

This block sequences the commands that software sends to a line printer mechanism. A command either prints a line and then moves the paper, or only moves the paper. A four-bit forms code picks the paper motion: space zero, one or two lines, or skip forward until the carriage-tape channel holes sensed at a line cover a requested pattern. The mechanism is reduced to event pulses: print cycle finished, one line advanced together with the channel holes sensed at the new line, and a set of error conditions.

Errors fall into two classes. Immediate errors land in the 8-bit status register at once and abort any command in progress. Deferred errors wait in a side store and enter the status register only when the next command is accepted. The interrupt for a printed line is raised as the paper advance starts, not after it ends. This lets software issue the next command while the paper is still moving. If a new print phase ends while an earlier advance is still running, its interrupt waits for that advance to finish. A test request returns the status byte and clears it. A skip that never finds its channel holes within a programmable number of lines locks the controller until an operator clear.

Top module: `lp_cmd_ctrl`

## Requirements
- R1: A command on `cmd_valid` is accepted, with `cmd_ack` high in the same cycle, only when no print phase or hand-off is outstanding and the runaway lock is clear. Otherwise it is ignored and changes nothing.
- R2: An accepted print command (`cmd_ctrl`=0) raises `print_run` from the next cycle until the cycle after `print_done`. A control command (`cmd_ctrl`=1) moves paper without ever raising `print_run`.
- R3: After the print phase (or at once for a control command), the paper advance starts and the interrupt is raised in the same clock edge. If an earlier advance is still running, both wait until it ends, and `irq` stays low meanwhile.
- R4: Forms codes 4'b0000, 4'b0001 and 4'b0010 move the paper 0, 1 and 2 lines: `feed_run` falls after that many `line_adv` pulses, and code 0000 never raises it.
- R5: Forms code 4'b1ttt skips paper. `feed_run` falls at the first `line_adv` whose `chan_sense` has a 1 in every position where ttt has a 1 (ttt=111 is home paper).
- R6: During spacing (not skipping), a `line_adv` with `chan_sense`=3'b001 (form overflow channel) records a deferred form-overflow error, status bit 6, even if spacing continues.
- R7: A skip that sees `runaway_limit` consecutive non-matching advances stops the paper and records a deferred runaway error, status bit 1. Every command is then rejected until `op_clear` is pulsed.
- R8: Immediate errors set status bits at once: `err_bar` bit 4, `err_parity` bit 3, `err_mem` bit 2, `err_abn` bit 0. If a print phase, hand-off or paper advance is active, all of them stop and an interrupt is raised.
- R9: Deferred errors (`paper_low` bit 7, overflow bit 6, runaway bit 1) move to the status register when the next command is accepted. That command then ends at once, with no print and no feed, and raises an interrupt.
- R10: A command with `cmd_inh`=1 raises no interrupt from any of its events.
- R11: A `test_req` pulse makes `test_valid` high in the next cycle, with `test_data` holding the status byte, where bit 5 is the pending interrupt. The status byte and `irq` are then cleared.
- R12: After reset, `irq`, `print_run`, `feed_run` and the status byte are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_ctrl | input | 1 | 1 = paper motion only, 0 = print then move |
| cmd_inh | input | 1 | Suppress all interrupts of this command |
| cmd_forms | input | 4 | Forms code |
| cmd_ack | output | 1 | Command accepted (same cycle) |
| print_done | input | 1 | Print cycle finished |
| line_adv | input | 1 | One line of paper advanced |
| chan_sense | input | 3 | Channel holes sensed at the new line |
| runaway_limit | input | LIM_W | Maximum skip lines before runaway |
| err_bar | input | 1 | Bar mismatch error (immediate) |
| err_parity | input | 1 | Parity error (immediate) |
| err_mem | input | 1 | Memory overload error (immediate) |
| err_abn | input | 1 | Abnormal / not ready (immediate) |
| paper_low | input | 1 | Paper low (deferred) |
| op_clear | input | 1 | Operator clear of runaway lock |
| test_req | input | 1 | Read and clear status |
| test_valid | output | 1 | Status byte valid |
| test_data | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| print_run | output | 1 | Print phase active |
| feed_run | output | 1 | Paper advance active |

## Verification
The bench overlaps a second command with a running paper advance. A design that raised the interrupt on print completion regardless of the feed would flag it while the paper still moves. Random forms codes and channel patterns check the exact advance at which spacing or a skip stops, that overflow is seen only while spacing, and that a skip with no matching holes runs away at the limit and locks. A design that moved deferred errors in at once, or accepted the next command normally, would show them early or print after a transfer. Immediate errors are raised both while idle and while active, and with and without the inhibit bit, to catch a controller that aborts or interrupts in the wrong case.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int ST_W     = 8;
    localparam int ST_PLOW  = 7;
    localparam int ST_OVF   = 6;
    localparam int ST_PEND  = 5;
    localparam int ST_BAR   = 4;
    localparam int ST_PAR   = 3;
    localparam int ST_MEM   = 2;
    localparam int ST_RUN   = 1;
    localparam int ST_ABN   = 0;

    localparam logic [2:0] CH_OVERFLOW = 3'b001;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_PRINT = 2'd1,
        P_WAIT  = 2'd2
    } pstate_t;

    typedef struct packed {
        logic       ctrl;
        logic       inh;
        logic [3:0] forms;
    } cmd_t;

    function automatic logic chan_hit(input logic [2:0] sensed, input logic [2:0] want);
        return (sensed & want) == want;
    endfunction

endpackage

// File: rtl/lp_feed.sv
module lp_feed
    import lp_pkg::*;
#(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [3:0]       forms,
    input  logic             kill,
    input  logic             line_adv,
    input  logic [2:0]       chan,
    input  logic [LIM_W-1:0] limit,
    output logic             busy,
    output logic             ovf_evt,
    output logic             run_evt
);

    logic             skip_q;
    logic [2:0]       tgt_q;
    logic [1:0]       left_q;
    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W-1:0] cnt_nx;
    logic             adv, hit, done;

    always_comb begin
        adv     = line_adv && busy;
        hit     = skip_q && chan_hit(chan, tgt_q);
        cnt_nx  = cnt_q + 1'b1;
        ovf_evt = adv && !skip_q && (chan == CH_OVERFLOW);
        run_evt = adv && skip_q && !hit && (cnt_nx >= limit);
        done    = adv && (skip_q ? (hit || run_evt) : (left_q == 2'd1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            skip_q <= 1'b0;
            tgt_q  <= '0;
            left_q <= '0;
            cnt_q  <= '0;
        end else if (kill) begin
            busy <= 1'b0;
        end else if (start) begin
            skip_q <= forms[3];
            tgt_q  <= forms[2:0];
            left_q <= forms[1:0];
            cnt_q  <= '0;
            busy   <= forms[3] || (forms[1:0] != 2'd0);
        end else if (done) begin
            busy <= 1'b0;
        end else if (adv) begin
            left_q <= left_q - 2'd1;
            cnt_q  <= cnt_nx;
        end
    end

endmodule

// File: rtl/lp_status.sv
module lp_status
    import lp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] imm_set,
    input  logic [ST_W-1:0] def_set,
    input  logic            xfer,
    input  logic            pend_set,
    input  logic            clr,
    output logic [ST_W-1:0] stat,
    output logic            def_any
);

    logic [ST_W-1:0] def_q;
    logic [ST_W-1:0] pend_v;

    always_comb begin
        pend_v         = '0;
        pend_v[ST_PEND] = pend_set;
        def_any        = |def_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat  <= '0;
            def_q <= '0;
        end else begin
            stat  <= (clr ? '0 : stat) | imm_set | (xfer ? def_q : '0) | pend_v;
            def_q <= (xfer ? '0 : def_q) | def_set;
        end
    end

endmodule

// File: rtl/lp_cmd_ctrl.sv
module lp_cmd_ctrl
    import lp_pkg::*;
#(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_ctrl,
    input  logic             cmd_inh,
    input  logic [3:0]       cmd_forms,
    output logic             cmd_ack,
    input  logic             print_done,
    input  logic             line_adv,
    input  logic [2:0]       chan_sense,
    input  logic [LIM_W-1:0] runaway_limit,
    input  logic             err_bar,
    input  logic             err_parity,
    input  logic             err_mem,
    input  logic             err_abn,
    input  logic             paper_low,
    input  logic             op_clear,
    input  logic             test_req,
    output logic             test_valid,
    output logic [7:0]       test_data,
    output logic             irq,
    output logic             print_run,
    output logic             feed_run
);

    pstate_t         pst;
    cmd_t            cur;
    logic            locked;
    logic            def_any;
    logic            pend_set;
    logic            imm_any;
    logic            wait_st;
    logic            active, kill, handoff, feed_start;
    logic            ovf_evt, run_evt;
    logic [ST_W-1:0] imm_set, def_set, stat;

    always_comb begin
        imm_set         = '0;
        imm_set[ST_BAR] = err_bar;
        imm_set[ST_PAR] = err_parity;
        imm_set[ST_MEM] = err_mem;
        imm_set[ST_ABN] = err_abn;
        imm_any         = |imm_set;

        def_set          = '0;
        def_set[ST_PLOW] = paper_low;
        def_set[ST_OVF]  = ovf_evt;
        def_set[ST_RUN]  = run_evt;

        wait_st    = (pst == P_WAIT);
        active     = (pst != P_IDLE) || feed_run;
        kill       = active && imm_any;
        cmd_ack    = cmd_valid && (pst == P_IDLE) && !locked;
        handoff    = wait_st && !feed_run && !kill;
        feed_start = handoff;
        pend_set   = (kill && !cur.inh) ||
                     (handoff && !cur.inh) ||
                     (cmd_ack && def_any && !cmd_inh);
        print_run  = (pst == P_PRINT);
        irq        = stat[ST_PEND];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pst <= P_IDLE;
            cur <= '0;
        end else if (kill) begin
            pst <= P_IDLE;
        end else if (cmd_ack) begin
            cur <= '{ctrl: cmd_ctrl, inh: cmd_inh, forms: cmd_forms};
            if (def_any)       pst <= P_IDLE;
            else if (cmd_ctrl) pst <= P_WAIT;
            else               pst <= P_PRINT;
        end else if (pst == P_PRINT && print_done) begin
            pst <= P_WAIT;
        end else if (handoff) begin
            pst <= P_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           locked <= 1'b0;
        else if (run_evt)  locked <= 1'b1;
        else if (op_clear) locked <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            test_valid <= 1'b0;
            test_data  <= '0;
        end else begin
            test_valid <= test_req;
            if (test_req) test_data <= stat;
        end
    end

    lp_feed #(.LIM_W(LIM_W)) u_feed (
        .clk(clk), .rst(rst), .start(feed_start), .forms(cur.forms),
        .kill(kill), .line_adv(line_adv), .chan(chan_sense),
        .limit(runaway_limit), .busy(feed_run),
        .ovf_evt(ovf_evt), .run_evt(run_evt)
    );

    lp_status u_status (
        .clk(clk), .rst(rst), .imm_set(imm_set), .def_set(def_set),
        .xfer(cmd_ack), .pend_set(pend_set), .clr(test_req),
        .stat(stat), .def_any(def_any)
    );

endmodule

// File: rtl/lp_cmd_ctrl_chk.sv
module lp_cmd_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic cmd_ack,
    input logic cmd_ctrl,
    input logic op_clear,
    input logic test_req,
    input logic test_valid,
    input logic irq,
    input logic print_run,
    input logic feed_run,
    input logic locked,
    input logic def_any,
    input logic pend_set,
    input logic imm_any,
    input logic wait_st
);

    // R2
    print_start_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ack && !cmd_ctrl && !def_any && !imm_any |=> print_run);

    // R7
    lock_reject_chk: assert property (@(posedge clk) disable iff (rst)
        locked |-> !cmd_ack);

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (print_run || feed_run) && imm_any |=> !print_run && !feed_run);

    // R3
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        feed_run && wait_st && !imm_any && !irq |=> !irq);

    // R11
    test_resp_chk: assert property (@(posedge clk) disable iff (rst)
        test_req |=> test_valid);

    // R11
    test_clear_chk: assert property (@(posedge clk) disable iff (rst)
        test_req && !pend_set |=> !irq);

endmodule

bind lp_cmd_ctrl lp_cmd_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .cmd_ack(cmd_ack), .cmd_ctrl(cmd_ctrl),
    .op_clear(op_clear), .test_req(test_req), .test_valid(test_valid),
    .irq(irq), .print_run(print_run), .feed_run(feed_run),
    .locked(locked), .def_any(def_any), .pend_set(pend_set),
    .imm_any(imm_any), .wait_st(wait_st)
);

// File: tb/test_lp_cmd_ctrl.sv
`timescale 1ns/1ps
module test_lp_cmd_ctrl;

    localparam int LIM_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 0, cmd_ctrl = 0, cmd_inh = 0;
    logic [3:0] cmd_forms = '0;
    logic cmd_ack;
    logic print_done = 0, line_adv = 0;
    logic [2:0] chan_sense = '0;
    logic [LIM_W-1:0] runaway_limit = 8'd4;
    logic err_bar = 0, err_parity = 0, err_mem = 0, err_abn = 0, paper_low = 0;
    logic op_clear = 0, test_req = 0;
    logic test_valid, irq, print_run, feed_run;
    logic [7:0] test_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    lp_cmd_ctrl #(.LIM_W(LIM_W)) i_lp_cmd_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ctrl(cmd_ctrl),
        .cmd_inh(cmd_inh), .cmd_forms(cmd_forms), .cmd_ack(cmd_ack),
        .print_done(print_done), .line_adv(line_adv), .chan_sense(chan_sense),
        .runaway_limit(runaway_limit), .err_bar(err_bar), .err_parity(err_parity),
        .err_mem(err_mem), .err_abn(err_abn), .paper_low(paper_low),
        .op_clear(op_clear), .test_req(test_req), .test_valid(test_valid),
        .test_data(test_data), .irq(irq), .print_run(print_run), .feed_run(feed_run)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_deferred(input logic plow, input logic ovf, input logic runa);
        return {plow, ovf, 4'b0000, runa, 1'b0};
    endfunction

    function automatic logic skip_match(input logic [2:0] ch, input logic [2:0] want);
        return (ch & want) == want;
    endfunction

    task automatic issue(input logic c, input logic h, input logic [3:0] f, output logic ok);
        cmd_valid = 1; cmd_ctrl = c; cmd_inh = h; cmd_forms = f;
        #1 ok = cmd_ack;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic ptest(output logic [7:0] st);
        test_req = 1;
        @(negedge clk);
        test_req = 0;
        chk("R11 valid", {7'd0, test_valid}, 8'd1);
        st = test_data;
    endtask

    task automatic adv(input logic [2:0] ch);
        line_adv = 1; chan_sense = ch;
        @(negedge clk);
        line_adv = 0;
    endtask

    task automatic pdone();
        print_done = 1;
        @(negedge clk);
        print_done = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic ok;
        logic [7:0] st;
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));

        cyc(3);
        rst = 0;
        cyc(1);

        // R12 reset state
        chk("R12 irq", {7'd0, irq}, 8'd0);
        chk("R12 print_run", {7'd0, print_run}, 8'd0);
        chk("R12 feed_run", {7'd0, feed_run}, 8'd0);
        ptest(st); chk("R12 status", st, 8'h00);

        // R1 R2 R3 R4 print, space 1
        issue(0, 0, 4'b0001, ok);
        chk("R1 ack", {7'd0, ok}, 8'd1);
        chk("R2 print_run", {7'd0, print_run}, 8'd1);
        pdone();
        chk("R2 print ends", {7'd0, print_run}, 8'd0);
        chk("R3 irq before handoff", {7'd0, irq}, 8'd0);
        cyc(1);
        chk("R3 irq at feed start", {7'd0, irq}, 8'd1);
        chk("R4 feed starts", {7'd0, feed_run}, 8'd1);
        adv(3'b000);
        chk("R4 one line", {7'd0, feed_run}, 8'd0);
        ptest(st); chk("R11 pending bit", st, 8'h20);
        chk("R11 irq cleared", {7'd0, irq}, 8'd0);
        ptest(st); chk("R11 cleared", st, 8'h00);

        // R3 overlap with running feed
        issue(0, 0, 4'b0010, ok);
        pdone(); cyc(1);
        chk("R3 feed run", {7'd0, feed_run}, 8'd1);
        ptest(st); chk("R3 first irq", st, 8'h20);
        issue(0, 0, 4'b0000, ok);
        chk("R1 overlap ack", {7'd0, ok}, 8'd1);
        pdone();
        issue(0, 0, 4'b0001, ok);
        chk("R1 reject while waiting", {7'd0, ok}, 8'd0);
        cyc(2);
        chk("R3 irq delayed", {7'd0, irq}, 8'd0);
        adv(3'b000);
        chk("R4 two lines pending", {7'd0, feed_run}, 8'd1);
        adv(3'b000);
        chk("R4 two lines done", {7'd0, feed_run}, 8'd0);
        chk("R3 not yet", {7'd0, irq}, 8'd0);
        cyc(1);
        chk("R3 delayed irq", {7'd0, irq}, 8'd1);
        chk("R4 space 0 no feed", {7'd0, feed_run}, 8'd0);
        ptest(st); chk("R3 status", st, 8'h20);

        // R6 R9 overflow during spacing, control command
        issue(1, 0, 4'b0010, ok);
        chk("R2 control no print", {7'd0, print_run}, 8'd0);
        cyc(1);
        adv(3'b001); adv(3'b000);
        chk("R6 spacing continues past overflow", {7'd0, feed_run}, 8'd0);
        ptest(st); chk("R9 overflow still deferred", st, 8'h20);
        issue(0, 1, 4'b0000, ok);
        chk("R9 transfer terminates", {7'd0, print_run}, 8'd0);
        ptest(st); chk("R6 overflow bit", st, 8'h40);

        // R5 skip to home, no overflow during skip
        issue(1, 1, 4'b1111, ok);
        cyc(1);
        adv(3'b000); chk("R5 skip continues", {7'd0, feed_run}, 8'd1);
        adv(3'b001); chk("R5 skip continues 2", {7'd0, feed_run}, 8'd1);
        adv(3'b111); chk("R5 skip stops", {7'd0, feed_run}, 8'd0);
        issue(0, 1, 4'b0000, ok);
        chk("R6 no overflow in skip", {7'd0, print_run}, 8'd1);
        pdone(); cyc(2);
        ptest(st); chk("R10 inhibited", st, 8'h00);

        // R7 runaway and lock
        issue(1, 1, 4'b1011, ok);
        cyc(1);
        adv(3'b001); adv(3'b001); adv(3'b001);
        chk("R7 still skipping", {7'd0, feed_run}, 8'd1);
        adv(3'b001);
        chk("R7 runaway stop", {7'd0, feed_run}, 8'd0);
        issue(0, 0, 4'b0000, ok);
        chk("R7 locked reject", {7'd0, ok}, 8'd0);
        ptest(st); chk("R7 reject no effect", st, 8'h00);
        op_clear = 1; cyc(1); op_clear = 0;
        issue(0, 0, 4'b0000, ok);
        chk("R7 accepted after clear", {7'd0, ok}, 8'd1);
        ptest(st); chk("R7 runaway bit", st, 8'h22);

        // R8 immediate errors
        issue(0, 0, 4'b0001, ok);
        err_parity = 1; cyc(1); err_parity = 0;
        chk("R8 abort print", {7'd0, print_run}, 8'd0);
        chk("R8 irq", {7'd0, irq}, 8'd1);
        ptest(st); chk("R8 parity", st, 8'h28);
        issue(0, 1, 4'b0001, ok);
        err_bar = 1; cyc(1); err_bar = 0;
        chk("R10 abort no irq", {7'd0, irq}, 8'd0);
        ptest(st); chk("R8 bar", st, 8'h10);
        issue(1, 0, 4'b0010, ok);
        cyc(1);
        err_abn = 1; cyc(1); err_abn = 0;
        chk("R8 abort feed", {7'd0, feed_run}, 8'd0);
        ptest(st); chk("R8 abnormal", st, 8'h21);
        err_mem = 1; cyc(1); err_mem = 0;
        chk("R8 idle no irq", {7'd0, irq}, 8'd0);
        ptest(st); chk("R8 mem", st, 8'h04);

        // R9 paper low
        paper_low = 1; cyc(1); paper_low = 0;
        ptest(st); chk("R9 paper low deferred", st, 8'h00);
        issue(0, 0, 4'b0000, ok);
        ptest(st); chk("R9 paper low moved", st, 8'hA0);

        // R10 inhibit on normal command
        issue(0, 1, 4'b0001, ok);
        pdone(); cyc(1);
        chk("R10 feed runs", {7'd0, feed_run}, 8'd1);
        chk("R10 no irq", {7'd0, irq}, 8'd0);
        adv(3'b000); cyc(2);
        ptest(st); chk("R10 status", st, 8'h00);

        // R4 R5 R6 R7 random forms and channels
        runaway_limit = 8'd6;
        for (int t = 0; t < 40; t++) begin
            logic [3:0] f;
            logic busy, ovf, runa;
            int left, cnt;
            int unsigned sel;
            sel = $urandom_range(0, 3);
            f = (sel < 3) ? {2'b00, sel[1:0]} : {1'b1, 3'($urandom_range(0, 7))};
            issue(1, 1, f, ok);
            chk("R1 random ack", {7'd0, ok}, 8'd1);
            cyc(1);
            busy = f[3] || (f[1:0] != 2'b00);
            left = int'(f[1:0]); cnt = 0; ovf = 0; runa = 0;
            chk("R4 feed start", {7'd0, feed_run}, {7'd0, busy});
            while (busy) begin
                logic [2:0] ch;
                ch = 3'($urandom_range(0, 7));
                adv(ch);
                if (f[3]) begin
                    if (skip_match(ch, f[2:0])) busy = 0;
                    else begin
                        cnt++;
                        if (cnt >= 6) begin runa = 1; busy = 0; end
                    end
                end else begin
                    if (ch == 3'b001) ovf = 1;
                    left--;
                    if (left == 0) busy = 0;
                end
                chk(f[3] ? "R5 skip step" : "R4 space step", {7'd0, feed_run}, {7'd0, busy});
            end
            if (runa) begin
                op_clear = 1; cyc(1); op_clear = 0;
            end
            issue(0, 1, 4'b0000, ok);
            if (exp_deferred(1'b0, ovf, runa) != 8'h00) begin
                chk("R9 random terminate", {7'd0, print_run}, 8'd0);
                ptest(st);
                chk(runa ? "R7 random" : "R6 random", st, exp_deferred(1'b0, ovf, runa));
            end else begin
                chk("R9 random no defer", {7'd0, print_run}, 8'd1);
                pdone(); cyc(2);
                ptest(st); chk("R6 random clean", st, 8'h00);
            end
        end

        finish_run();
    end

endmodule